// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block maps a physical memory address onto one of six DRAM rows and drives one active-low row strobe for the chosen row. Software programs a small file of boundary registers through a byte-offset write/read port. Each register holds a cumulative upper limit in 4 MB units: the total size of its own row plus every row below it. The size of a row is therefore its boundary minus the boundary of the row beneath it. A row whose boundary equals the one beneath it has zero size.

For each access the decoder takes the address field in 4 MB units, A[28:22], and compares it with every boundary. It selects the lowest row whose boundary is greater than that field. The result is registered, so the strobe and an out-of-range flag appear one clock after the access is presented. Two registers have write side effects: a write to the fourth or fifth register also copies the same value into every register above it. For this reason software programs the rows in ascending order. The highest boundary sets top of memory. Usable memory is never larger than 256 MB.

Top module: `dram_row_decoder`

## Requirements
- R1: After a synchronous active-low reset, all six boundary registers read 0x02, every strobe is high (inactive), and the out-of-range flag is low.
- R2: A read at offset 0x60+i (i = 0..5) returns register i on `cfg_rdata` in the same cycle. Bit 7 always reads 0, and bit 7 of written data is discarded.
- R3: A write to offset 0x60, 0x61 or 0x62 updates only that register, and the new value is visible from the next cycle.
- R4: A write to offset 0x63 loads the written value into the registers at 0x63, 0x64 and 0x65.
- R5: A write to offset 0x64 loads the value into 0x64 and 0x65. A write to 0x65 changes only 0x65. Neither write alters any lower register.
- R6: Writes to offsets other than 0x60–0x65 change no register, including 0xE0, which differs from 0x60 only in bit 7. Reads at such offsets return 0x00.
- R7: One cycle after a valid access, `ras_n[i]` is low for the lowest row i whose boundary is greater than A[28:22], and every other strobe is high.
- R8: A row whose boundary equals the boundary of the row below it is never selected. An address past the lower row goes to the next row with nonzero size.
- R9: One cycle after a valid access with A[28:22] at or above the boundary at 0x65, no strobe is low and `acc_oor` is high.
- R10: One cycle after a valid access with any of A[31:28] set (256 MB or more), no strobe is low and `acc_oor` is high, whatever the boundaries hold.
- R11: One cycle after a cycle with `acc_valid` low, all strobes are high and `acc_oor` is low.
- R12: At most one strobe is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the boundary register port |
| cfg_ofs | input | 8 | Byte offset for both write and read |
| cfg_wdata | input | 8 | Write data; bit 7 ignored |
| cfg_rdata | output | 8 | Combinational read data at `cfg_ofs` |
| acc_valid | input | 1 | A memory access is presented this cycle |
| acc_addr | input | 32 | Physical byte address of the access |
| ras_n | output | 6 | Registered active-low row strobes, bit i for row i |
| acc_oor | output | 1 | Registered flag: access lies beyond usable memory |

## Verification
The bench decodes addresses against the reset layout, where only row 0 exists. It then uses a layout with rows of unequal size and one empty row in the middle. Probes on both sides of every boundary show off-by-one errors in the compare and show whether the empty row is skipped. A top boundary above 256 MB, together with addresses just below and at the cap, separates the top-of-memory limit from the fixed cap. A long run of random writes at offsets just inside and just outside the mapped window, mixed with random accesses, shows whether cascaded writes reach the right registers and whether a write in the same cycle as an access leaves that access decoded against the old boundaries.

// File: rtl/drd_pkg.sv
// Package: shared constants for the DRAM row boundary decoder.
// Assumes: a 32-bit byte address and 4 MB row granularity.
package drd_pkg;
    localparam int unsigned DRD_ROWS       = 6;     // number of DRAM rows
    localparam int unsigned DRD_LIM_W      = 7;     // boundary field width
    localparam int unsigned DRD_REG_W      = 8;     // register width on the port
    localparam int unsigned DRD_OFS_W      = 8;     // register offset width
    localparam int unsigned DRD_BASE_OFS   = 'h60;  // offset of row 0 boundary
    localparam int unsigned DRD_CASCADE    = 3;     // first row whose write fans upward
    localparam int unsigned DRD_RST_VAL    = 2;     // reset boundary value
    localparam int unsigned DRD_ADDR_W     = 32;    // access address width
    localparam int unsigned DRD_GRAN_LSB   = 22;    // log2 of 4 MB
    localparam int unsigned DRD_CAP_LOG2   = 6;     // 256 MB cap = 2**6 units
endpackage

// File: rtl/drd_regfile.sv
// Module: boundary register file with cascading writes.
// Holds one LIM_W-bit cumulative boundary per row. A write to row k
// with k >= CASCADE_FROM also loads every row above k. Offsets outside
// the window are ignored on write and read as zero.
// Assumes: one shared offset for read and write, synchronous active-low reset.
module drd_regfile #(
    parameter int unsigned NUM_ROWS     = drd_pkg::DRD_ROWS,
    parameter int unsigned LIM_W        = drd_pkg::DRD_LIM_W,
    parameter int unsigned REG_W        = drd_pkg::DRD_REG_W,
    parameter int unsigned OFS_W        = drd_pkg::DRD_OFS_W,
    parameter int unsigned BASE_OFS     = drd_pkg::DRD_BASE_OFS,
    parameter int unsigned CASCADE_FROM = drd_pkg::DRD_CASCADE,
    parameter int unsigned RST_VAL      = drd_pkg::DRD_RST_VAL
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [OFS_W-1:0]                 ofs,
    input  logic [REG_W-1:0]                 wr_data,
    output logic [REG_W-1:0]                 rd_data,
    output logic [NUM_ROWS-1:0][LIM_W-1:0]   bnd
);
    localparam logic [OFS_W-1:0] OFS_LO = OFS_W'(BASE_OFS);
    localparam logic [OFS_W-1:0] OFS_HI = OFS_W'(BASE_OFS + NUM_ROWS);
    localparam int unsigned      PAD_W  = REG_W - LIM_W;

    logic             in_win;
    logic [OFS_W-1:0] idx;
    logic             unused_msb;

    // Decode whether the offset falls inside the register window.
    assign in_win     = (ofs >= OFS_LO) && (ofs < OFS_HI);
    assign idx        = ofs - OFS_LO;
    assign unused_msb = ^wr_data[REG_W-1:LIM_W];

    generate
        for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
            logic load;
            // Load on a direct hit, or on a cascading write to a lower row.
            if (i > CASCADE_FROM) begin : g_casc
                assign load = wr_en && in_win &&
                              ((idx == OFS_W'(i)) ||
                               ((idx >= OFS_W'(CASCADE_FROM)) && (idx < OFS_W'(i))));
            end else begin : g_plain
                assign load = wr_en && in_win && (idx == OFS_W'(i));
            end

            // Boundary storage for row i.
            always_ff @(posedge clk) begin
                if (!rst_n)    bnd[i] <= LIM_W'(RST_VAL);
                else if (load) bnd[i] <= wr_data[LIM_W-1:0];
            end
        end
    endgenerate

    // Read mux: zero-extend the selected boundary, or return zero outside the window.
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            if (in_win && (idx == OFS_W'(r))) rd_data = {{PAD_W{1'b0}}, bnd[r]};
        end
    end

    AST_CASCADE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == OFS_W'(BASE_OFS + CASCADE_FROM)) |=>
        (bnd[NUM_ROWS-1] == $past(wr_data[LIM_W-1:0]))); // R4

    AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_win) |=> $stable(bnd)); // R6

    AST_RD_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1] == 1'b0); // R2
endmodule

// File: rtl/drd_first_hit.sv
// Module: lowest-index first-one finder.
// Grants the lowest set bit of req. Assumes nothing about the pattern of req.
module drd_first_hit #(
    parameter int unsigned N = drd_pkg::DRD_ROWS
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;
    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            // Pass the grant only when no lower request is set.
            assign grant[i]  = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate
endmodule

// File: rtl/drd_row_select.sv
// Module: address-to-row decode with registered strobes.
// Compares the 4 MB address field with every cumulative boundary, picks
// the lowest row above it, and flags accesses past top of memory or past
// the fixed cap. Outputs are registered with one cycle of latency.
// Assumes: the boundaries come straight from the register file, so a write
// made in the same cycle is seen only by later accesses.
module drd_row_select #(
    parameter int unsigned NUM_ROWS = drd_pkg::DRD_ROWS,
    parameter int unsigned LIM_W    = drd_pkg::DRD_LIM_W,
    parameter int unsigned ADDR_W   = drd_pkg::DRD_ADDR_W,
    parameter int unsigned GRAN_LSB = drd_pkg::DRD_GRAN_LSB,
    parameter int unsigned CAP_LOG2 = drd_pkg::DRD_CAP_LOG2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_ROWS-1:0][LIM_W-1:0]  bnd,
    input  logic                            acc_valid,
    input  logic [ADDR_W-1:0]               acc_addr,
    output logic [NUM_ROWS-1:0]             ras_n,
    output logic                            acc_oor
);
    localparam int unsigned CAP_BIT = GRAN_LSB + CAP_LOG2;

    logic [LIM_W-1:0]    units;
    logic                above_cap;
    logic [NUM_ROWS-1:0] below;
    logic [NUM_ROWS-1:0] grant;
    logic                in_range;
    logic                unused_low;

    // Slice the access into 4 MB units and check it against the cap.
    assign units      = acc_addr[GRAN_LSB +: LIM_W];
    assign above_cap  = |acc_addr[ADDR_W-1:CAP_BIT];
    assign unused_low = ^acc_addr[GRAN_LSB-1:0];

    generate
        for (genvar i = 0; i < NUM_ROWS; i++) begin : g_cmp
            // Row i can claim the access when the address lies under its limit.
            assign below[i] = units < bnd[i];
        end
    endgenerate

    drd_first_hit #(.N(NUM_ROWS)) u_first (
        .req   (below),
        .grant (grant)
    );

    // Accept only accesses under both the top boundary and the cap.
    assign in_range = !above_cap && below[NUM_ROWS-1];

    // Register the strobes and the out-of-range flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n   <= '1;
            acc_oor <= 1'b0;
        end else begin
            ras_n   <= (acc_valid && in_range) ? ~grant : '1;
            acc_oor <= acc_valid && !in_range;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ras_n) <= 1); // R12

    AST_OOR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        acc_oor |-> (&ras_n)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> ((&ras_n) && !acc_oor)); // R11

    AST_CAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (|acc_addr[ADDR_W-1:CAP_BIT])) |=> acc_oor); // R10
endmodule

// File: rtl/dram_row_decoder.sv
// Module: top of the DRAM row boundary decoder.
// Joins the boundary register file to the row decode path.
// Assumes: a single clock domain and a synchronous active-low reset.
module dram_row_decoder #(
    parameter int unsigned NUM_ROWS     = drd_pkg::DRD_ROWS,
    parameter int unsigned LIM_W        = drd_pkg::DRD_LIM_W,
    parameter int unsigned REG_W        = drd_pkg::DRD_REG_W,
    parameter int unsigned OFS_W        = drd_pkg::DRD_OFS_W,
    parameter int unsigned BASE_OFS     = drd_pkg::DRD_BASE_OFS,
    parameter int unsigned CASCADE_FROM = drd_pkg::DRD_CASCADE,
    parameter int unsigned RST_VAL      = drd_pkg::DRD_RST_VAL,
    parameter int unsigned ADDR_W       = drd_pkg::DRD_ADDR_W,
    parameter int unsigned GRAN_LSB     = drd_pkg::DRD_GRAN_LSB,
    parameter int unsigned CAP_LOG2     = drd_pkg::DRD_CAP_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [OFS_W-1:0]     cfg_ofs,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic                 acc_valid,
    input  logic [ADDR_W-1:0]    acc_addr,
    output logic [NUM_ROWS-1:0]  ras_n,
    output logic                 acc_oor
);
    logic [NUM_ROWS-1:0][LIM_W-1:0] bnd;

    drd_regfile #(
        .NUM_ROWS(NUM_ROWS), .LIM_W(LIM_W), .REG_W(REG_W), .OFS_W(OFS_W),
        .BASE_OFS(BASE_OFS), .CASCADE_FROM(CASCADE_FROM), .RST_VAL(RST_VAL)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .ofs     (cfg_ofs),
        .wr_data (cfg_wdata),
        .rd_data (cfg_rdata),
        .bnd     (bnd)
    );

    drd_row_select #(
        .NUM_ROWS(NUM_ROWS), .LIM_W(LIM_W), .ADDR_W(ADDR_W),
        .GRAN_LSB(GRAN_LSB), .CAP_LOG2(CAP_LOG2)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .bnd       (bnd),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .ras_n     (ras_n),
        .acc_oor   (acc_oor)
    );
endmodule

// File: tb/dram_row_decoder_tb.sv
// Bench: behavioural reference model compared with the decoder on every clock.
module dram_row_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_ofs = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic [5:0]  ras_n;
    logic        acc_oor;

    int    checks = 0;
    int    failures = 0;
    int    model_bnd [6];
    logic [5:0] exp_ras = 6'h3F;
    logic  exp_oor = 1'b0;
    string prev_tag = "R1";

    always #10 clk = ~clk;

    dram_row_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ofs(cfg_ofs),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .ras_n(ras_n), .acc_oor(acc_oor)
    );

    function automatic logic [31:0] mb(input int m);
        return 32'(m) << 20;
    endfunction

    function automatic int model_read(input logic [7:0] o);
        if (o >= 8'h60 && o <= 8'h65) return model_bnd[o - 8'h60];
        return 0;
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // One clock: check outputs, drive inputs, check read data, advance the model.
    task automatic step(input logic wr, input logic [7:0] o, input logic [7:0] wd,
                        input logic av, input logic [31:0] aa, input string tag);
        int units, row, k;
        @(negedge clk);
        check(ras_n == exp_ras, prev_tag, "ras_n", int'(ras_n), int'(exp_ras));
        check(acc_oor == exp_oor, prev_tag, "acc_oor", int'(acc_oor), int'(exp_oor));
        check($countones(~ras_n) <= 1, "R12", "strobes low", $countones(~ras_n), 1);
        cfg_wr = wr; cfg_ofs = o; cfg_wdata = wd; acc_valid = av; acc_addr = aa;
        #1;
        check(cfg_rdata == 8'(model_read(o)), tag, "cfg_rdata", int'(cfg_rdata), model_read(o));
        // Expected decode from the boundaries held before this edge.
        units = int'(aa[28:22]);
        exp_ras = 6'h3F;
        exp_oor = 1'b0;
        if (av) begin
            if (aa[31:28] != 0 || units >= model_bnd[5]) exp_oor = 1'b1;
            else begin
                row = -1;
                for (int r = 5; r >= 0; r--) if (units < model_bnd[r]) row = r;
                exp_ras[row] = 1'b0;
            end
        end
        // Register update with the cascading side effect.
        if (wr && o >= 8'h60 && o <= 8'h65) begin
            k = o - 8'h60;
            for (int r = 0; r < 6; r++)
                if (r == k || (k >= 3 && r > k)) model_bnd[r] = int'(wd & 8'h7F);
        end
        prev_tag = tag;
    endtask

    task automatic rd(input logic [7:0] o, input string tag);
        step(1'b0, o, 8'h00, 1'b0, 32'h0, tag);
    endtask

    task automatic wr(input logic [7:0] o, input logic [7:0] d, input string tag);
        step(1'b1, o, d, 1'b0, 32'h0, tag);
    endtask

    task automatic acc(input logic [31:0] a, input string tag);
        step(1'b0, 8'h00, 8'h00, 1'b1, a, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int r = 0; r < 6; r++) model_bnd[r] = 2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values and quiet outputs.
        for (int r = 0; r < 6; r++) rd(8'(8'h60 + r), "R1");
        // R7/R9 with the reset layout: row 0 covers 0..8 MB.
        acc(32'h0, "R7");
        acc(mb(8) - 1, "R7");
        acc(mb(8), "R9");
        // R3: lower rows written alone; row 2 left empty.
        wr(8'h60, 8'h04, "R3");
        wr(8'h61, 8'h06, "R3");
        wr(8'h62, 8'h06, "R3");
        for (int r = 0; r < 6; r++) rd(8'(8'h60 + r), "R3");
        // R4: the fourth register fans out upward.
        wr(8'h63, 8'h0A, "R4");
        rd(8'h64, "R4"); rd(8'h65, "R4"); rd(8'h62, "R4");
        // R5: the fifth register fans out to the top only; the top stands alone.
        wr(8'h64, 8'h0C, "R5");
        rd(8'h63, "R5"); rd(8'h65, "R5");
        wr(8'h65, 8'h10, "R5");
        rd(8'h64, "R5"); rd(8'h65, "R5");
        // R2: bit 7 of written data is dropped and reads as zero.
        wr(8'h62, 8'h86, "R2");
        rd(8'h62, "R2");
        // R7/R8: boundaries 4,6,6,10,12,16.
        acc(mb(0), "R7");
        acc(mb(16) - 1, "R7");
        acc(mb(16), "R7");
        acc(mb(24) - 1, "R7");
        acc(mb(24), "R8");
        acc(mb(40), "R7");
        acc(mb(63), "R7");
        acc(mb(64), "R9");
        acc(mb(100), "R9");
        // R10: top boundary beyond the cap; the cap still holds.
        wr(8'h65, 8'h7F, "R10");
        acc(mb(255), "R10");
        acc(mb(256), "R10");
        acc(32'h8000_0000, "R10");
        // R6: writes outside the window have no effect.
        wr(8'h5F, 8'h01, "R6");
        wr(8'h66, 8'h01, "R6");
        wr(8'hE0, 8'h01, "R6");
        for (int r = 0; r < 6; r++) rd(8'(8'h60 + r), "R6");
        rd(8'h66, "R6"); rd(8'hE0, "R6");
        acc(mb(1), "R6");
        // R11: no access, no strobe.
        step(1'b0, 8'h60, 8'h00, 1'b0, mb(1), "R11");
        step(1'b0, 8'h60, 8'h00, 1'b0, mb(300), "R11");
        // Random mix of writes and accesses, including same-cycle overlap.
        for (int n = 0; n < 400; n++) begin
            logic        w;
            logic [7:0]  o;
            logic [31:0] a;
            w = ($urandom % 4) == 0;
            o = 8'(8'h5E + ($urandom % 10));
            a = (($urandom % 8) == 0) ? $urandom : ($urandom % 32'h1200_0000);
            step(w, o, 8'($urandom), ($urandom % 5) != 0, a, "R7");
        end
        step(1'b0, 8'h00, 8'h00, 1'b0, 32'h0, "R11");
        step(1'b0, 8'h00, 8'h00, 1'b0, 32'h0, "R11");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule